// File: doc/BRIEF.md
# Privilege-Filtered Event Counter Unit

This block counts hardware events in five 40-bit counters. Two are general-purpose counters and three are fixed-function counters. A counter advances on its event pulse only when two conditions hold. The first is that its own ring-qualification bits admit the current privilege ring. The second is that its bit in a global enable register is set. When a counter wraps from all ones to zero, it sets a sticky flag in a 64-bit status word. Each counter can turn that flag into a level interrupt request. Two further status bits are set by external pulses: one reports a trace-buffer overflow and one reports a change of monitoring state.

Software reaches the unit through a simple register port. It presents an address on every cycle, and the read data for that address appears after one clock. A write is a single-cycle strobe. A dedicated write-one-to-clear register is the only way to remove a status flag.

Top module: `pmu_evcnt`

## Requirements
- R1: After a synchronous reset, every control register, counter and status bit reads zero, and `irq` is low.
- R2: Each counter has a 4-bit control nibble. Nibble bit 0 admits events at ring 0 (`ring`==0). Nibble bit 1 admits events at any ring above 0. With both bits at 00 the counter holds, and with 11 it counts at every ring.
- R3: A counter increments on an event only when its global-enable bit and its ring qualification are both true. The global-enable register (address 2) has bit 0 for GP0, bit 1 for GP1 and bits 32..34 for fixed counters 0..2.
- R4: Counters are 40 bits wide and wrap from all ones to zero. At the same clock edge as the wrap, the counter's status flag is set. Status flags sit at bits 0, 1 and 32..34, in the same order as the global enables.
- R5: Status flags are sticky. A write to address 4 clears each status bit whose write-data bit is 1. If a flag is set and cleared in the same cycle, the set takes priority.
- R6: `irq` is registered. It is high one cycle after any counter flag is set while that counter's nibble bit 3 is also set. It falls one cycle after no such pair remains.
- R7: A pulse on `ds_ovf` sets status bit 62, and a pulse on `hw_chg` sets status bit 63. Neither bit drives `irq`.
- R8: Reserved bits are ignored on write and read as zero. This covers nibble bit 2 and bits above the last nibble, global-enable bits outside 0, 1 and 32..34, and counter bits 63..40. Writes to the status address (3) are ignored, and address 4 reads as zero.
- R9: If a counter write and an event reach the same counter in the same cycle, the written value is stored and no flag is set.
- R10: Register map: 0 holds the fixed-counter control, with nibble n at bits 4n+3..4n. 1 holds the GP control, with nibble n at bits 4n+3..4n. 2 is global enable, 3 is status and 4 is flag clear. 8 and 9 are GP0 and GP1, and 10 to 12 are fixed counters 0 to 2. `rd_data` shows the register addressed in the previous cycle.
- R11: The general-purpose counters follow the same nibble format for ring qualification and interrupt enable as the fixed counters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fx_evt | input | 3 | Event pulses for fixed counters 0..2 |
| gp_evt | input | 2 | Event pulses for general-purpose counters 0..1 |
| ring | input | 2 | Current privilege ring, 0 is most privileged |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address for read and write |
| reg_wdata | input | 64 | Register write data |
| ds_ovf | input | 1 | Trace-buffer overflow pulse, sets status bit 62 |
| hw_chg | input | 1 | Monitoring-state change pulse, sets status bit 63 |
| rd_data | output | 64 | Registered read data for the previous cycle's address |
| irq | output | 1 | Level overflow interrupt request |

## Verification
The delays follow from the registers in each path. An event or a write held across one rising edge changes a counter and its status flag at that edge. `rd_data` shows the result one edge after the address is presented. `irq` follows the flag one edge later still. The bench drives every stimulus for exactly one edge between falling edges, and then reads through the port. As a result, each read lands at least two edges after the stimulus. `irq` is sampled only after such a read, when it has already settled.

// File: rtl/pmu_pkg.sv
package pmu_pkg;
  localparam int NGP  = 2;
  localparam int NFX  = 3;
  localparam int NCNT = NGP + NFX;
  localparam int DW   = 64;
  localparam int AW   = 4;

  localparam logic [AW-1:0] A_FCTL = 4'd0;
  localparam logic [AW-1:0] A_GCTL = 4'd1;
  localparam logic [AW-1:0] A_GEN  = 4'd2;
  localparam logic [AW-1:0] A_STAT = 4'd3;
  localparam logic [AW-1:0] A_OCLR = 4'd4;
  localparam int            A_CNT0 = 8;

  localparam int BIT_DS  = 62;
  localparam int BIT_CHG = 63;

  // counter index i: 0..NGP-1 general purpose, then fixed counters
  function automatic int stat_pos(input int i);
    return (i < NGP) ? i : 32 + i - NGP;
  endfunction

  // bits of a control register that hold state: nibble bits 0,1,3
  function automatic logic [DW-1:0] nib_mask(input int n);
    logic [DW-1:0] m;
    m = '0;
    for (int k = 0; k < n; k++) m[4*k +: 4] = 4'b1011;
    return m;
  endfunction
endpackage

// File: rtl/pmu_counter.sv
module pmu_counter #(
  parameter int W = 40
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         evt,
  input  logic         ring_hi,
  input  logic [1:0]   ring_en,
  input  logic         gen,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] cnt,
  output logic         wrap
);
  logic qual, inc;

  always_comb begin
    qual = ring_hi ? ring_en[1] : ring_en[0];
    inc  = evt & gen & qual;
    wrap = inc & ~wr & (&cnt);
  end

  always_ff @(posedge clk) begin
    if (rst)      cnt <= '0;
    else if (wr)  cnt <= wdata;
    else if (inc) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/pmu_status.sv
module pmu_status
  import pmu_pkg::*;
#(
  parameter int N = NCNT
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  wrap,
  input  logic [N-1:0]  pie,
  input  logic          ds_evt,
  input  logic          chg_evt,
  input  logic          clr_we,
  input  logic [DW-1:0] clr_data,
  output logic [DW-1:0] status,
  output logic          irq
);
  logic [DW-1:0] set_v, pie_v, clr_v;

  always_comb begin
    set_v = '0;
    pie_v = '0;
    for (int i = 0; i < N; i++) begin
      set_v[stat_pos(i)] = wrap[i];
      pie_v[stat_pos(i)] = pie[i];
    end
    set_v[BIT_DS]  = ds_evt;
    set_v[BIT_CHG] = chg_evt;
    clr_v = clr_we ? clr_data : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      status <= '0;
      irq    <= 1'b0;
    end else begin
      status <= (status & ~clr_v) | set_v;
      irq    <= |(status & pie_v);
    end
  end
endmodule

// File: rtl/pmu_evcnt.sv
module pmu_evcnt
  import pmu_pkg::*;
#(
  parameter int CW = 40
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NFX-1:0] fx_evt,
  input  logic [NGP-1:0] gp_evt,
  input  logic [1:0]    ring,
  input  logic          reg_we,
  input  logic [AW-1:0] reg_addr,
  input  logic [DW-1:0] reg_wdata,
  input  logic          ds_ovf,
  input  logic          hw_chg,
  output logic [DW-1:0] rd_data,
  output logic          irq
);
  logic [NCNT-1:0][1:0]    ren_q;
  logic [NCNT-1:0]         pie_q;
  logic [NCNT-1:0]         gen_q;
  logic [NCNT-1:0][CW-1:0] cnt;
  logic [NCNT-1:0]         wrap;
  logic [DW-1:0]           status;
  logic                    ring_hi;
  logic [DW-1:0]           rd_next;

  assign ring_hi = |ring;

  // control, enable registers
  always_ff @(posedge clk) begin
    if (rst) begin
      ren_q <= '0;
      pie_q <= '0;
      gen_q <= '0;
    end else if (reg_we) begin
      for (int i = 0; i < NCNT; i++) begin
        if (i < NGP && reg_addr == A_GCTL) begin
          ren_q[i] <= reg_wdata[4*i +: 2];
          pie_q[i] <= reg_wdata[4*i + 3];
        end
        if (i >= NGP && reg_addr == A_FCTL) begin
          ren_q[i] <= reg_wdata[4*(i-NGP) +: 2];
          pie_q[i] <= reg_wdata[4*(i-NGP) + 3];
        end
        if (reg_addr == A_GEN) gen_q[i] <= reg_wdata[stat_pos(i)];
      end
    end
  end

  for (genvar i = 0; i < NCNT; i++) begin : g_cnt
    logic ev, wr;
    if (i < NGP) begin : g_gp
      assign ev = gp_evt[i];
    end else begin : g_fx
      assign ev = fx_evt[i-NGP];
    end
    assign wr = reg_we && (reg_addr == AW'(A_CNT0 + i));

    pmu_counter #(.W(CW)) u_ctr (
      .clk    (clk),
      .rst    (rst),
      .evt    (ev),
      .ring_hi(ring_hi),
      .ring_en(ren_q[i]),
      .gen    (gen_q[i]),
      .wr     (wr),
      .wdata  (reg_wdata[CW-1:0]),
      .cnt    (cnt[i]),
      .wrap   (wrap[i])
    );
  end

  pmu_status #(.N(NCNT)) u_stat (
    .clk     (clk),
    .rst     (rst),
    .wrap    (wrap),
    .pie     (pie_q),
    .ds_evt  (ds_ovf),
    .chg_evt (hw_chg),
    .clr_we  (reg_we && reg_addr == A_OCLR),
    .clr_data(reg_wdata),
    .status  (status),
    .irq     (irq)
  );

  // read mux
  always_comb begin
    rd_next = '0;
    for (int i = 0; i < NCNT; i++) begin
      if (i < NGP && reg_addr == A_GCTL) begin
        rd_next[4*i +: 2] = ren_q[i];
        rd_next[4*i + 3]  = pie_q[i];
      end
      if (i >= NGP && reg_addr == A_FCTL) begin
        rd_next[4*(i-NGP) +: 2] = ren_q[i];
        rd_next[4*(i-NGP) + 3]  = pie_q[i];
      end
      if (reg_addr == A_GEN) rd_next[stat_pos(i)] = gen_q[i];
      if (reg_addr == AW'(A_CNT0 + i)) rd_next = DW'(cnt[i]);
    end
    if (reg_addr == A_STAT) rd_next = status;
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_next;
  end
endmodule

// File: rtl/pmu_evcnt_chk.sv
module pmu_evcnt_chk
  import pmu_pkg::*;
#(
  parameter int CW = 40
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    reg_we,
  input logic [AW-1:0]           reg_addr,
  input logic [DW-1:0]           reg_wdata,
  input logic [DW-1:0]           rd_data,
  input logic                    irq,
  input logic [DW-1:0]           status,
  input logic [NCNT-1:0]         gen_q,
  input logic [NCNT-1:0][CW-1:0] cnt
);
  localparam int FX0 = NGP;
  localparam logic [DW-1:0] FMASK = nib_mask(NFX);

  logic wr_fx0, clr32;
  assign wr_fx0 = reg_we && reg_addr == AW'(A_CNT0 + FX0);
  assign clr32  = reg_we && reg_addr == A_OCLR && reg_wdata[32];

  AST_RSV_FCTL: assert property (@(posedge clk) disable iff (rst)
    ($past(reg_addr) == A_FCTL) |-> ((rd_data & ~FMASK) == '0)); // R8

  AST_OCLR_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
    ($past(reg_addr) == A_OCLR) |-> (rd_data == '0)); // R8

  AST_HOLD_DISABLED: assert property (@(posedge clk) disable iff (rst)
    (!gen_q[FX0] && !wr_fx0) |=> $stable(cnt[FX0])); // R3

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
    (status[32] && !clr32) |=> status[32]); // R5

  AST_WRAP_FLAG: assert property (@(posedge clk) disable iff (rst)
    ((cnt[FX0] == '0) && $past(&cnt[FX0]) && !$past(wr_fx0)) |-> status[32]); // R4

  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past((|status[33:32]) || status[34] || (|status[1:0]))); // R6
endmodule

bind pmu_evcnt pmu_evcnt_chk #(.CW(CW)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .reg_we   (reg_we),
  .reg_addr (reg_addr),
  .reg_wdata(reg_wdata),
  .rd_data  (rd_data),
  .irq      (irq),
  .status   (status),
  .gen_q    (gen_q),
  .cnt      (cnt)
);

// File: tb/pmu_evcnt_tb.sv
module pmu_evcnt_tb;
  logic        clk = 0;
  logic        rst = 1;
  logic [2:0]  fx_evt = '0;
  logic [1:0]  gp_evt = '0;
  logic [1:0]  ring = '0;
  logic        reg_we = 0;
  logic [3:0]  reg_addr = '0;
  logic [63:0] reg_wdata = '0;
  logic        ds_ovf = 0, hw_chg = 0;
  logic [63:0] rd_data;
  logic        irq;

  int checks = 0, fails = 0;
  logic [63:0] v;
  localparam logic [63:0] ONES40 = 64'h0000_00FF_FFFF_FFFF;

  always #4 clk = ~clk;

  pmu_evcnt u_dut (
    .clk(clk), .rst(rst), .fx_evt(fx_evt), .gp_evt(gp_evt), .ring(ring),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .ds_ovf(ds_ovf), .hw_chg(hw_chg), .rd_data(rd_data), .irq(irq)
  );

  // {ctl_en[1:0], ring[1:0], gen, per-event increment}
  localparam int NV = 8;
  localparam logic [5:0] VEC [NV] = '{
    {2'b00, 2'd0, 1'b1, 1'b0},
    {2'b01, 2'd0, 1'b1, 1'b1},
    {2'b01, 2'd3, 1'b1, 1'b0},
    {2'b10, 2'd0, 1'b1, 1'b0},
    {2'b10, 2'd2, 1'b1, 1'b1},
    {2'b11, 2'd1, 1'b1, 1'b1},
    {2'b11, 2'd0, 1'b0, 1'b0},
    {2'b11, 2'd0, 1'b1, 1'b1}
  };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [63:0] d);
    @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 0; reg_wdata = '0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [63:0] d);
    @(negedge clk); reg_addr = a;
    @(negedge clk); d = rd_data;
  endtask

  task automatic pulse(input logic [2:0] f, input logic [1:0] g);
    @(negedge clk); fx_evt = f; gp_evt = g;
    @(negedge clk); fx_evt = '0; gp_evt = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;

    // R1 reset state
    rd(4'd0, v);  chk("R1 fctl", v, 0);
    rd(4'd2, v);  chk("R1 gen", v, 0);
    rd(4'd3, v);  chk("R1 status", v, 0);
    rd(4'd10, v); chk("R1 cnt fx0", v, 0);
    chk("R1 irq", {63'd0, irq}, 0);

    // R2/R3 qualification table, three events per entry
    for (int k = 0; k < NV; k++) begin
      wr(4'd0, {62'd0, VEC[k][5:4]});
      wr(4'd2, {31'd0, VEC[k][1], 32'd0});
      wr(4'd10, 64'd0);
      ring = VEC[k][3:2];
      repeat (3) pulse(3'b001, 2'b00);
      rd(4'd10, v);
      chk($sformatf("R2 R3 vector %0d", k), v, VEC[k][0] ? 64'd3 : 64'd0);
    end
    ring = 0;

    // R4 wrap, R6 irq
    wr(4'd0, 64'hB);
    wr(4'd2, 64'h1_0000_0000);
    wr(4'd10, ONES40);
    pulse(3'b001, 2'b00);
    rd(4'd10, v); chk("R4 wrap to zero", v, 0);
    rd(4'd3, v);  chk("R4 flag bit32", v, 64'h1_0000_0000);
    chk("R6 irq set", {63'd0, irq}, 1);

    // R5 sticky / R8 status write ignored
    wr(4'd4, 64'h1);
    rd(4'd3, v); chk("R5 other clear keeps flag", v, 64'h1_0000_0000);
    wr(4'd3, 64'h0);
    rd(4'd3, v); chk("R8 status write ignored", v, 64'h1_0000_0000);
    rd(4'd4, v); chk("R8 clear reg reads zero", v, 0);
    wr(4'd4, 64'h1_0000_0000);
    rd(4'd3, v); chk("R5 cleared", v, 0);
    chk("R6 irq drops", {63'd0, irq}, 0);

    // R6 no interrupt without enable, then enabling raises it
    wr(4'd0, 64'h3);
    wr(4'd10, ONES40);
    pulse(3'b001, 2'b00);
    rd(4'd3, v); chk("R4 flag again", v, 64'h1_0000_0000);
    chk("R6 masked irq", {63'd0, irq}, 0);
    wr(4'd0, 64'hB);
    rd(4'd0, v); chk("R6 pie written", v, 64'hB);
    chk("R6 irq after enable", {63'd0, irq}, 1);

    // R5 set wins over same-cycle clear
    wr(4'd4, 64'h1_0000_0000);
    wr(4'd10, ONES40);
    @(negedge clk); reg_we = 1; reg_addr = 4'd4; reg_wdata = 64'h1_0000_0000; fx_evt = 3'b001;
    @(negedge clk); reg_we = 0; reg_wdata = '0; fx_evt = '0;
    rd(4'd3, v); chk("R5 set beats clear", v, 64'h1_0000_0000);
    wr(4'd4, 64'h1_0000_0000);

    // R9 write beats event, upper bits dropped
    @(negedge clk); reg_we = 1; reg_addr = 4'd10; reg_wdata = 64'hFFFF_0000_0000_0007; fx_evt = 3'b001;
    @(negedge clk); reg_we = 0; reg_wdata = '0; fx_evt = '0;
    rd(4'd10, v); chk("R9 write wins R8 upper bits", v, 64'd7);
    @(negedge clk); reg_we = 1; reg_addr = 4'd10; reg_wdata = 64'd0; fx_evt = 3'b001;
    @(negedge clk); reg_we = 0; fx_evt = '0;
    wr(4'd10, ONES40);
    @(negedge clk); reg_we = 1; reg_addr = 4'd10; reg_wdata = ONES40; fx_evt = 3'b001;
    @(negedge clk); reg_we = 0; reg_wdata = '0; fx_evt = '0;
    rd(4'd3, v); chk("R9 no flag on write", v, 0);

    // R7 external status bits
    @(negedge clk); ds_ovf = 1; hw_chg = 1;
    @(negedge clk); ds_ovf = 0; hw_chg = 0;
    rd(4'd3, v); chk("R7 bits 62 63", v, 64'hC000_0000_0000_0000);
    chk("R7 no irq", {63'd0, irq}, 0);
    wr(4'd4, 64'hC000_0000_0000_0000);
    rd(4'd3, v); chk("R7 cleared", v, 0);

    // R8 reserved bits, R10 map
    wr(4'd0, '1);
    rd(4'd0, v); chk("R8 fctl mask", v, 64'hBBB);
    wr(4'd2, '1);
    rd(4'd2, v); chk("R8 R10 gen mask", v, 64'h7_0000_0003);
    wr(4'd1, '1);
    rd(4'd1, v); chk("R8 R11 gctl mask", v, 64'hBB);

    // R11 general-purpose counter ring filter and overflow
    wr(4'd0, 64'h0);
    wr(4'd1, 64'h20);
    wr(4'd9, 64'd0);
    ring = 2'd1;
    repeat (2) pulse(3'b000, 2'b10);
    ring = 2'd0;
    pulse(3'b000, 2'b10);
    rd(4'd9, v);  chk("R11 gp1 ring>0 only", v, 64'd2);
    rd(4'd8, v);  chk("R10 gp0 untouched", v, 0);
    wr(4'd9, ONES40);
    ring = 2'd3;
    pulse(3'b000, 2'b10);
    rd(4'd3, v);  chk("R4 R11 gp1 flag bit1", v, 64'h2);
    chk("R11 no irq without nibble bit3", {63'd0, irq}, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule